// File: doc/BRIEF.md
# Correlated-Stream Stochastic Edge Detector

This block takes four k-bit pixel intensities from a 2x2 window and returns a diagonal-gradient edge magnitude. It works in the stochastic domain. Each pixel becomes a bit stream whose probability of a 1 is proportional to its value. The two pixels on each diagonal are compared against the same pseudo-random sequence. Because they share that source, their streams overlap as much as their values allow. A single XOR on such a pair therefore yields a stream whose density is the absolute difference of the two pixels.

A 2:1 multiplexer merges the two difference streams. Its select comes from a third, unrelated random source that is 1 about half the time, so the result is the scaled sum of the two differences. The multiplexer gives this sum whatever the relation between its two data streams. A counter then tallies the 1s over 2^K cycles and turns the result back into a binary value.

A run begins with a one-cycle start pulse. The pixel inputs must stay steady for the whole run. When the run ends, `done` rises and the count is held until the next start.

Top module: `sc_edge`

## Requirements
- R1: After reset, `done` is 0 and `edgeMag` is 0.
- R2: A start accepted while no run is active makes `done` rise exactly 2^K rising clock edges after the edge that sampled start (256 for K=8). `done` then stays 1, and `edgeMag` stays constant, until the next start.
- R3: A start that arrives while a run is active is ignored. The run keeps its original length and ends at the original time.
- R4: The edge that accepts a start clears `edgeMag` to 0 and lowers `done`.
- R5: If each diagonal pair holds equal values (nw == se and ne == sw), the final `edgeMag` is exactly 0.
- R6: The final `edgeMag` lies within ±20 LSB of (|nw − se| + |ne − sw|) / 2, using integer division. This holds both when the two differences are equal and when they differ.
- R7: The sign of a difference does not matter. Swapping which pixel of a pair is larger leaves the result within the R6 tolerance of the same ideal value.
- R8: During a run, `edgeMag` increases by at most 1 per clock edge and never exceeds 2^K − 1. After n edges of a run it is at most n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion run (one-cycle pulse) |
| pixNw | input | K | Upper-left pixel, paired with pixSe |
| pixNe | input | K | Upper-right pixel, paired with pixSw |
| pixSw | input | K | Lower-left pixel |
| pixSe | input | K | Lower-right pixel |
| done | output | 1 | Run complete; result valid |
| edgeMag | output | K | Count of output 1s: edge magnitude |

## Verification
`done` becomes visible after the 2^K-th rising edge that follows the edge sampling start. The bench counts edges from that point and checks that `done` appears at exactly that count. It checks the cleared result one edge after start. It compares the final magnitude only once `done` is seen, and checks it again 20 edges later to confirm the value holds. All outputs are sampled on the falling edge. A second start is injected mid-run, and a partial count is read at a known edge number, so that the ignore rule and the per-edge growth bound are checked against exact cycle positions.

// File: rtl/sc_edge_pkg.sv
package sc_edge_pkg;
  typedef struct packed {
    logic load;  // reseed sources and clear count
    logic run;   // advance sources and accumulate
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } runState_t;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      state <= SEED;
    else if (load)  state <= SEED;
    else if (step)  state <= (state >> 1) ^ (state[0] ? MASK : ZERO);
  end

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != ZERO);
endmodule

// File: rtl/sc_edge_ctrl.sv
module sc_edge_ctrl
  import sc_edge_pkg::*;
#(
  parameter int K = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output ctlStrobe_t strobe,
  output logic       done
);
  localparam logic [K-1:0] LAST = '1;
  localparam logic [K-1:0] STEP = 1;

  runState_t    state;
  logic [K-1:0] cycCnt;
  logic         accept;

  assign accept = start && (state != ST_RUN);

  always_comb begin
    strobe.load = accept;
    strobe.run  = (state == ST_RUN);
  end

  assign done = (state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else if (accept) begin
      state  <= ST_RUN;
      cycCnt <= '0;
    end else if (state == ST_RUN) begin
      cycCnt <= cycCnt + STEP;
      if (cycCnt == LAST) state <= ST_FIN;
    end
  end

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cycCnt != LAST) |=> (state == ST_RUN));
  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  // R3
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && cycCnt != LAST) |=>
      (state == ST_RUN && cycCnt == $past(cycCnt) + STEP));
  // R4
  start_lowers_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !done);
endmodule

// File: rtl/sc_edge_dp.sv
module sc_edge_dp
  import sc_edge_pkg::*;
#(
  parameter int K = 8,
  parameter int NSRC = 3,
  parameter logic [NSRC-1:0][K-1:0] SRC_MASK = {8'h8E, 8'hB8, 8'hB8},
  parameter logic [NSRC-1:0][K-1:0] SRC_SEED = {8'h5A, 8'hC3, 8'h01}
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   strobe,
  input  logic [K-1:0] pixNw,
  input  logic [K-1:0] pixNe,
  input  logic [K-1:0] pixSw,
  input  logic [K-1:0] pixSe,
  output logic [K-1:0] count
);
  localparam logic [K-1:0] MID  = 1 << (K - 1);
  localparam logic [K-1:0] FULL = '1;
  localparam logic [K-1:0] ONE  = 1;

  logic [NSRC-1:0][K-1:0] rnd;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : gSrc
      sc_lfsr #(.W(K), .MASK(SRC_MASK[g]), .SEED(SRC_SEED[g])) uLfsr (
        .clk  (clk),
        .rstN (rstN),
        .load (strobe.load),
        .step (strobe.run),
        .state(rnd[g])
      );
    end
  endgenerate

  // diagonal NW/SE shares source 0, NE/SW shares source 1
  logic bitNw, bitSe, bitNe, bitSw;
  logic diffMain, diffAnti, selHalf, outBit;

  always_comb begin
    bitNw    = pixNw > rnd[0];
    bitSe    = pixSe > rnd[0];
    bitNe    = pixNe > rnd[1];
    bitSw    = pixSw > rnd[1];
    diffMain = bitNw ^ bitSe;
    diffAnti = bitNe ^ bitSw;
    selHalf  = rnd[2] >= MID;
    outBit   = selHalf ? diffAnti : diffMain;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    count <= '0;
    else if (strobe.load)                         count <= '0;
    else if (strobe.run && outBit && count != FULL) count <= count + ONE;
  end

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == '0));
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (count == $past(count) || count == $past(count) + ONE));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.run) |=> $stable(count));
  // R5
  equal_pairs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && pixNw == pixSe && pixNe == pixSw) |-> !outBit);
endmodule

// File: rtl/sc_edge.sv
module sc_edge
  import sc_edge_pkg::*;
#(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [K-1:0] pixNw,
  input  logic [K-1:0] pixNe,
  input  logic [K-1:0] pixSw,
  input  logic [K-1:0] pixSe,
  output logic         done,
  output logic [K-1:0] edgeMag
);
  ctlStrobe_t strobe;

  sc_edge_ctrl #(.K(K)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .done  (done)
  );

  sc_edge_dp #(.K(K)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .pixNw (pixNw),
    .pixNe (pixNe),
    .pixSw (pixSw),
    .pixSe (pixSe),
    .count (edgeMag)
  );
endmodule

// File: tb/sc_edge_test.sv
module sc_edge_test;
  localparam int CLK_PERIOD = 10;
  localparam int K = 8;
  localparam int RUN_LEN = 1 << K;
  localparam int TOL = 20;
  localparam int NVEC = 8;
  // {nw, ne, sw, se}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd100, 8'd50,  8'd50,  8'd100},
    {8'd120, 8'd80,  8'd40,  8'd40 },
    {8'd40,  8'd40,  8'd120, 8'd120},
    {8'd200, 8'd10,  8'd90,  8'd180},
    {8'd5,   8'd250, 8'd250, 8'd85 },
    {8'd128, 8'd0,   8'd64,  8'd128},
    {8'd255, 8'd255, 8'd0,   8'd0  },
    {8'd0,   8'd30,  8'd0,   8'd30 }
  };

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [K-1:0] pixNw = 0, pixNe = 0, pixSw = 0, pixSe = 0;
  logic done;
  logic [K-1:0] edgeMag;

  int tests = 0;
  int fails = 0;
  int wdog = 0;

  sc_edge #(.K(K)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .pixNw(pixNw), .pixNe(pixNe), .pixSw(pixSw), .pixSe(pixSe),
    .done(done), .edgeMag(edgeMag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp, input int tol);
    tests++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // start a run; optional second start at edge pokeAt; returns edges until done
  task automatic runCase(input logic [31:0] v, input int pokeAt, output int cyc);
    @(negedge clk);
    {pixNw, pixNe, pixSw, pixSe} = v;
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check("R4 cleared result", int'(edgeMag), 0, 0);
    check("R4 done low", int'(done), 0, 0);
    cyc = 0;
    while (!done && cyc < 4 * RUN_LEN) begin
      if (cyc == pokeAt) start = 1;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      cyc++;
      if (cyc == 100 && !done && int'(edgeMag) > 100) begin
        tests++; fails++;
        $display("FAIL R8 partial: actual %0d expected <= 100", edgeMag);
      end
    end
  endtask

  initial begin
    int cyc;
    int ideal;
    int held;
    // R1 reset state
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 done", int'(done), 0, 0);
    check("R1 result", int'(edgeMag), 0, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", int'(edgeMag), 0, 0);

    // R6 R7 R5: vector table
    for (int i = 0; i < NVEC; i++) begin
      runCase(VEC[i], -1, cyc);
      check("R2 run length", cyc, RUN_LEN, 0);
      ideal = (absd(int'(VEC[i][31:24]), int'(VEC[i][7:0])) +
               absd(int'(VEC[i][23:16]), int'(VEC[i][15:8]))) / 2;
      check("R6 R7 magnitude", int'(edgeMag), ideal, TOL);
    end

    // R5 exact zero for equal pairs
    runCase({8'd77, 8'd200, 8'd200, 8'd77}, -1, cyc);
    check("R5 equal pairs", int'(edgeMag), 0, 0);

    // R2 done and result hold without start
    runCase({8'd150, 8'd20, 8'd60, 8'd90}, -1, cyc);
    held = int'(edgeMag);
    repeat (20) @(negedge clk);
    check("R2 done held", int'(done), 1, 0);
    check("R2 result held", int'(edgeMag), held, 0);

    // R3 second start mid-run ignored; R8 partial bound checked inside
    runCase({8'd90, 8'd30, 8'd70, 8'd10}, 50, cyc);
    check("R3 run length unchanged", cyc, RUN_LEN, 0);
    check("R3 magnitude", int'(edgeMag), (80 + 40) / 2, TOL);

    // R8 maximum inputs never exceed range
    runCase({8'd255, 8'd0, 8'd255, 8'd0}, -1, cyc);
    check("R8 max bound", int'(edgeMag), 255, TOL);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule